// File: doc/BRIEF.md
# Banked Hardware-Monitor Register File

This block is the register file of a hardware-monitor device. A host reaches it through a two-location parallel port. The location selected by `addr_sel = 0` holds a 7-bit index. The location selected by `addr_sel = 1` transfers data to or from the register that the index points at.

Data accesses to some registers step the index forward by one, so a host can walk a run of registers without reloading the index. The upper index window 0x60–0x7F reaches the same storage as 0x20–0x3F. Measurement registers and identification registers refuse writes.

A bank-select register chooses between the main map and up to two alternate temperature banks. Each alternate bank overlays indices 0x50–0x56 with its own seven-entry store. Sensor values arrive on input ports and load the measurement registers on every clock. Writing a one to bit 7 of the configuration register at 0x40 returns the whole file to its defaults, except for the serial-address register at 0x48.

Top module: `hwmon_regfile`

## Requirements
- R1: A write to the index location stores bits 6:0 of `wdata`. A read of the index location returns `{1'b0, index}`. The index is 0 after reset.
- R2: While the active bank is 0, each data strobe (`rd_en` or `wr_en` with `addr_sel = 1`) at index 0x41, 0x43, 0x45, 0x56 or 0x60–0x7E adds one to the index at the edge that ends the strobe. Every other data strobe, and every data strobe in bank 1 or 2, leaves the index unchanged.
- R3: Indices 0x60–0x7F read and write the same bytes as indices 0x20–0x3F.
- R4: Data writes are ignored at indices 0x20–0x2A, 0x41, 0x42, 0x4F, 0x58 and 0x60–0x6A.
- R5: A write to 0x4E selects the active bank from bits 2:0. Bit 0 selects bank 0 and has the highest priority. Bit 1 selects bank 1 and comes next. Bit 2 selects bank 2 and comes last. A value with none of these bits set leaves the bank unchanged. Reset selects bank 0.
- R6: Reading 0x4F returns bits 15:8 of `VENDOR_ID` when bit 7 of register 0x4E is 1, and bits 7:0 when it is 0.
- R7: In bank 1 or 2, indices 0x50–0x56 reach that bank's own seven-entry store. Entry 0x50 is the high byte and entry 0x51 the low byte of that bank's `xtemp_in` field. Both are read-only. Index 0x57 and above stay in the main map. In bank 0, indices 0x50–0x56 use the main map.
- R8: A data write of a value with bit 7 set to 0x40, in any bank, restores every register and both alternate stores to their defaults one cycle later. It also selects bank 0 and keeps the current value of 0x48.
- R9: Reset defaults: 0x40=0x01, 0x46=0x40, 0x47=0x50, 0x48=`SER_ADDR_RST`, 0x49=0x02, 0x4A=0x01, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80, 0x57=0x80, 0x58=`CHIP_ID`. All other main bytes reset to 0.
- R10: In each alternate store, entry 0x53 resets to 0x4B, entry 0x55 resets to 0x50, and entries 0x52, 0x54 and 0x56 reset to 0.
- R11: Register 0x20+k holds byte k of `meas_in`, sampled at every clock edge.
- R12: A writable index that has no function reads back the last value written to it, and 0 after reset.
- R13: `rdata` follows the current index combinationally. A data write is visible on the first read after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | 0 = index location, 1 = data location |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe (drives index advance) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected location |
| meas_in | input | NUM_MEAS*8 | Sensor bytes for 0x20 upward |
| xtemp_in | input | NUM_XBANK*16 | Per-bank temperature, high byte first |

## Verification
The bench builds the block with its default parameters: eleven measurement bytes, two alternate banks and a 7-bit index. At that size all 128 indices can be swept several times: after reset, for index advance, and after a full write pass. An arithmetic model predicts every read-back, including aliasing, protected bytes and the vendor byte. With both alternate banks present, the bench can exercise the bank-select priority, the separation of the two stores and the software-initialise path from a non-zero bank.

// File: rtl/hwmon_pkg.sv
`timescale 1ns/1ps
package hwmon_pkg;
   localparam int IDX_W = 7;
   typedef logic [IDX_W-1:0] idx_t;
   typedef logic [7:0]       byte_t;

   localparam idx_t IX_CFG    = 7'h40;
   localparam idx_t IX_SERADR = 7'h48;
   localparam idx_t IX_BANK   = 7'h4E;
   localparam idx_t IX_VID    = 7'h4F;
   localparam idx_t IX_CHIP   = 7'h58;
   localparam idx_t IX_ALIAS  = 7'h60;
   localparam idx_t ALIAS_OFS = 7'h40;
   localparam int   XB_ENTRIES = 7;

   function automatic logic is_autoinc(input idx_t ix);
      return (ix == 7'h41) || (ix == 7'h43) || (ix == 7'h45) || (ix == 7'h56) ||
             (ix >= 7'h60 && ix <= 7'h7E);
   endfunction

   function automatic logic is_ro_fixed(input idx_t ix);
      return (ix == 7'h41) || (ix == 7'h42) || (ix == IX_VID) || (ix == IX_CHIP);
   endfunction

   function automatic byte_t main_dflt(input idx_t ix, input byte_t ser, input byte_t chip);
      case (ix)
         7'h40:   return 8'h01;
         7'h46:   return 8'h40;
         7'h47:   return 8'h50;
         7'h48:   return ser;
         7'h49:   return 8'h02;
         7'h4A:   return 8'h01;
         7'h4B:   return 8'h44;
         7'h4C:   return 8'h01;
         7'h4D:   return 8'h15;
         7'h4E:   return 8'h80;
         7'h57:   return 8'h80;
         7'h58:   return chip;
         default: return 8'h00;
      endcase
   endfunction

   function automatic byte_t xb_dflt(input int e);
      return (e == 3) ? 8'h4B : (e == 5) ? 8'h50 : 8'h00;
   endfunction
endpackage

// File: rtl/hwmon_index.sv
`timescale 1ns/1ps
module hwmon_index
   import hwmon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic idx_wr,
   input  idx_t idx_wdata,
   input  logic data_acc,
   input  logic bank0,
   output idx_t idx
);
   logic adv;
   assign adv = data_acc && bank0 && is_autoinc(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (idx_wr) idx <= idx_wdata;
      else if (adv)    idx <= idx + 1'b1;
   end

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> idx == $past(idx_wdata)); // R1
   AST_IDX_BANKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !bank0 && !idx_wr) |=> $stable(idx)); // R2
endmodule

// File: rtl/hwmon_bank_ctl.sv
`timescale 1ns/1ps
module hwmon_bank_ctl #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        sel_bits,
   input  logic              init,
   output logic [BANK_W-1:0] bank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bank <= '0;
      else if (init) bank <= '0;
      else if (load) begin
         if (sel_bits[0])      bank <= BANK_W'(0);
         else if (sel_bits[1]) bank <= BANK_W'(1);
         else if (sel_bits[2]) bank <= BANK_W'(2);
      end
   end

   AST_BANK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      bank != BANK_W'(3)); // R5
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sel_bits == 3'b000 && !init) |=> $stable(bank)); // R5
   AST_BANK_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> bank == '0); // R8
endmodule

// File: rtl/hwmon_xbank.sv
`timescale 1ns/1ps
module hwmon_xbank
   import hwmon_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        wr,
   input  logic [2:0]  sel,
   input  byte_t       wdata,
   input  logic [15:0] sensor,
   output byte_t       rd
);
   byte_t ent [XB_ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < XB_ENTRIES; e++) ent[e] <= xb_dflt(e);
      end else begin
         if (init) begin
            for (int e = 2; e < XB_ENTRIES; e++) ent[e] <= xb_dflt(e);
         end else if (wr && sel >= 3'd2 && sel < 3'(XB_ENTRIES)) begin
            ent[sel] <= wdata;
         end
         ent[0] <= sensor[15:8];
         ent[1] <= sensor[7:0];
      end
   end

   assign rd = (sel < 3'(XB_ENTRIES)) ? ent[sel] : 8'h00;

   AST_XB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !init && sel >= 3'd2 && sel < 3'(XB_ENTRIES)) |=> ent[$past(sel)] == $past(wdata)); // R7
   AST_XB_RO_HI: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ent[0] == $past(sensor[15:8])); // R7
endmodule

// File: rtl/hwmon_regfile.sv
`timescale 1ns/1ps
module hwmon_regfile
   import hwmon_pkg::*;
#(
   parameter int          NUM_MEAS     = 11,
   parameter int          NUM_XBANK    = 2,
   parameter logic [15:0] VENDOR_ID    = 16'h5CA3,
   parameter logic [7:0]  SER_ADDR_RST = 8'h2D,
   parameter logic [7:0]  CHIP_ID      = 8'h10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    addr_sel,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   input  logic [NUM_MEAS*8-1:0]   meas_in,
   input  logic [NUM_XBANK*16-1:0] xtemp_in
);
   localparam int MAIN_DEPTH = int'(IX_ALIAS);
   localparam int MEAS_BASE  = 32;
   localparam int MEAS_LAST  = MEAS_BASE + NUM_MEAS - 1;
   localparam int BANK_W     = 2;

   if (NUM_MEAS < 1 || NUM_MEAS > 32) begin : g_bad_meas
      $error("NUM_MEAS must lie in 1..32");
   end
   if (NUM_XBANK < 1 || NUM_XBANK > 2) begin : g_bad_xbank
      $error("NUM_XBANK must lie in 1..2");
   end

   idx_t              idx;
   logic [BANK_W-1:0] bank;
   byte_t             mem [MAIN_DEPTH];
   byte_t             xb_rd [NUM_XBANK];
   byte_t             xsel, rd_main;
   idx_t              phys;
   logic              data_wr, data_rd, idx_wr, in_xbank, ro_main, main_we, init_fire;

   assign data_wr  = wr_en && addr_sel;
   assign data_rd  = rd_en && addr_sel;
   assign idx_wr   = wr_en && !addr_sel;
   assign in_xbank = (bank != '0) && (int'(bank) <= NUM_XBANK) &&
                     (idx[6:4] == 3'h5) && (idx[3:0] < 4'(XB_ENTRIES));
   assign phys     = (idx >= IX_ALIAS) ? idx - ALIAS_OFS : idx;
   assign ro_main  = is_ro_fixed(idx) || (int'(phys) >= MEAS_BASE && int'(phys) <= MEAS_LAST);
   assign main_we  = data_wr && !in_xbank && !ro_main;
   assign init_fire = data_wr && !in_xbank && (idx == IX_CFG) && wdata[7];

   hwmon_index u_index (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(wdata[IDX_W-1:0]),
      .data_acc(data_wr || data_rd), .bank0(bank == '0), .idx(idx)
   );

   hwmon_bank_ctl #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(data_wr && idx == IX_BANK),
      .sel_bits(wdata[2:0]), .init(init_fire), .bank(bank)
   );

   for (genvar b = 0; b < NUM_XBANK; b++) begin : g_xb
      hwmon_xbank u_xb (
         .clk(clk), .rst_n(rst_n), .init(init_fire),
         .wr(data_wr && in_xbank && bank == BANK_W'(b + 1)),
         .sel(idx[2:0]), .wdata(wdata),
         .sensor(xtemp_in[b*16 +: 16]), .rd(xb_rd[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < MAIN_DEPTH; k++) mem[k] <= main_dflt(idx_t'(k), SER_ADDR_RST, CHIP_ID);
      end else begin
         if (init_fire) begin
            for (int k = 0; k < MAIN_DEPTH; k++)
               mem[k] <= (k == int'(IX_SERADR)) ? mem[k] : main_dflt(idx_t'(k), SER_ADDR_RST, CHIP_ID);
         end else if (main_we) begin
            mem[phys] <= wdata;
         end
         for (int m = 0; m < NUM_MEAS; m++) mem[MEAS_BASE + m] <= meas_in[m*8 +: 8];
      end
   end

   always_comb begin
      xsel = 8'h00;
      for (int b = 0; b < NUM_XBANK; b++)
         if (bank == BANK_W'(b + 1)) xsel = xb_rd[b];
   end

   assign rd_main = (idx == IX_VID) ? (mem[IX_BANK][7] ? VENDOR_ID[15:8] : VENDOR_ID[7:0])
                                    : mem[phys];
   assign rdata   = !addr_sel ? {1'b0, idx} : (in_xbank ? xsel : rd_main);

   AST_RO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !in_xbank && is_ro_fixed(idx) && idx != IX_VID) |=> mem[$past(phys)] == $past(mem[phys])); // R4
   AST_ALIAS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (main_we && idx >= IX_ALIAS) |=> mem[$past(idx) - ALIAS_OFS] == $past(wdata)); // R3
   AST_INIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      init_fire |=> (mem[IX_SERADR] == $past(mem[IX_SERADR])) && (mem[IX_CFG] == 8'h01)); // R8
   AST_MEAS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> mem[MEAS_BASE] == $past(meas_in[7:0])); // R11
endmodule

// File: tb/tb_hwmon_regfile.sv
`timescale 1ns/1ps
module tb_hwmon_regfile;
   localparam int          NM   = 11;
   localparam int          NX   = 2;
   localparam logic [15:0] VID  = 16'h5CA3;
   localparam logic [7:0]  SER  = 8'h2D;
   localparam logic [7:0]  CHIP = 8'h10;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_n, addr_sel, wr_en, rd_en;
   logic [7:0]      wdata, rdata;
   logic [NM*8-1:0] meas_in;
   logic [NX*16-1:0] xtemp_in;

   hwmon_regfile dut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .meas_in(meas_in), .xtemp_in(xtemp_in)
   );

   int n_chk = 0, n_fail = 0;
   logic [7:0] m_main [0:95];
   logic [7:0] m_xb [1:2][0:6];
   int m_bank;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input int ix);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s idx=%02h: got %02h expected %02h", tag, ix, act, exp);
      end
   endtask

   function automatic int phys(input int i);
      return (i >= 8'h60) ? i - 8'h40 : i;
   endfunction
   function automatic bit ro(input int i);
      return (i >= 8'h20 && i <= 8'h2A) || i == 8'h41 || i == 8'h42 || i == 8'h4F ||
             i == 8'h58 || (i >= 8'h60 && i <= 8'h6A);
   endfunction
   function automatic bit advs(input int i);
      return i == 8'h41 || i == 8'h43 || i == 8'h45 || i == 8'h56 || (i >= 8'h60 && i <= 8'h7E);
   endfunction

   function automatic logic [7:0] m_rd(input int i);
      int p;
      if (m_bank != 0 && i >= 8'h50 && i <= 8'h56) begin
         if (i == 8'h50) return xtemp_in[(m_bank-1)*16+8 +: 8];
         if (i == 8'h51) return xtemp_in[(m_bank-1)*16 +: 8];
         return m_xb[m_bank][i-8'h50];
      end
      if (i == 8'h4F) return m_main[8'h4E][7] ? VID[15:8] : VID[7:0];
      p = phys(i);
      if (p >= 8'h20 && p < 8'h20 + NM) return meas_in[(p-8'h20)*8 +: 8];
      return m_main[p];
   endfunction

   task automatic m_reset(input bit keep);
      logic [7:0] s;
      s = m_main[8'h48];
      for (int k = 0; k < 96; k++) m_main[k] = 8'h00;
      m_main[8'h40] = 8'h01; m_main[8'h46] = 8'h40; m_main[8'h47] = 8'h50;
      m_main[8'h48] = keep ? s : SER; m_main[8'h49] = 8'h02; m_main[8'h4A] = 8'h01;
      m_main[8'h4B] = 8'h44; m_main[8'h4C] = 8'h01; m_main[8'h4D] = 8'h15;
      m_main[8'h4E] = 8'h80; m_main[8'h57] = 8'h80; m_main[8'h58] = CHIP;
      for (int b = 1; b <= 2; b++)
         for (int e = 0; e < 7; e++) m_xb[b][e] = (e == 3) ? 8'h4B : (e == 5) ? 8'h50 : 8'h00;
      m_bank = 0;
   endtask

   task automatic m_wr(input int i, input logic [7:0] v);
      if (m_bank != 0 && i >= 8'h50 && i <= 8'h56) begin
         if (i >= 8'h52) m_xb[m_bank][i-8'h50] = v;
         return;
      end
      if (ro(i)) return;
      m_main[phys(i)] = v;
      if (i == 8'h40 && v[7]) m_reset(1'b1);
      if (i == 8'h4E) begin
         if (v[0]) m_bank = 0; else if (v[1]) m_bank = 1; else if (v[2]) m_bank = 2;
      end
   endtask

   task automatic acc(input bit sel, input bit wr, input bit rd, input logic [7:0] d,
                      output logic [7:0] q);
      @(negedge clk);
      addr_sel = sel; wr_en = wr; rd_en = rd; wdata = d;
      #1 q = rdata;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic set_idx(input int i);
      logic [7:0] q;
      acc(1'b0, 1'b1, 1'b0, 8'(i), q);
   endtask

   task automatic dwr(input int i, input logic [7:0] v);
      logic [7:0] q;
      set_idx(i);
      acc(1'b1, 1'b1, 1'b0, v, q);
      m_wr(i, v);
   endtask

   task automatic drd_chk(input int i, input string tag);
      logic [7:0] q, e;
      set_idx(i);
      e = m_rd(i);
      acc(1'b1, 1'b0, 1'b1, 8'h00, q);
      chk(tag, q, e, i);
   endtask

   function automatic string reset_tag(input int i);
      int p;
      p = phys(i);
      if (i == 8'h4F) return "R6";
      if (p >= 8'h20 && p <= 8'h2A) return "R11";
      if (i >= 8'h40 && i <= 8'h58) return "R9";
      return "R12";
   endfunction

   bit done = 1'b0;
   initial begin
      #900000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] q, v;
      rst_n = 1'b0; addr_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
      for (int k = 0; k < NM; k++) meas_in[k*8 +: 8] = 8'hA0 + 8'(k);
      xtemp_in = {16'h2A40, 16'h1980};
      for (int k = 0; k < 96; k++) m_main[k] = 8'h00;
      m_reset(1'b0);
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: index is zero after reset
      acc(1'b0, 1'b0, 1'b1, 8'h00, q);
      chk("R1", q, 8'h00, 0);

      // R9 R10 R11 R12 R6: reset values of every index in bank 0
      for (int i = 0; i < 128; i++) drd_chk(i, reset_tag(i));

      // R1: bit 7 of the index write is dropped
      set_idx(8'hC5);
      acc(1'b0, 1'b0, 1'b1, 8'h00, q);
      chk("R1", q, 8'h45, 8'h45);

      // R2: advance sweep over all indices, reads in bank 0
      for (int i = 0; i < 128; i++) begin
         set_idx(i);
         acc(1'b1, 1'b0, 1'b1, 8'h00, q);
         acc(1'b0, 1'b0, 1'b1, 8'h00, q);
         chk("R2", q, advs(i) ? 8'((i + 1) & 8'h7F) : 8'(i), i);
      end
      // R2: a write also advances
      set_idx(8'h43);
      acc(1'b1, 1'b1, 1'b0, 8'h12, q);
      m_wr(8'h43, 8'h12);
      acc(1'b0, 1'b0, 1'b1, 8'h00, q);
      chk("R2", q, 8'h44, 8'h43);

      // R3 R4 R12 R13: write every index, then read all back
      for (int i = 0; i < 128; i++) begin
         v = (i == 8'h40) ? 8'h11 : (i == 8'h4E) ? 8'h01 : 8'(i * 7 + 9);
         dwr(i, v);
      end
      for (int i = 0; i < 128; i++)
         drd_chk(i, ro(i) ? "R4" : (i >= 8'h60) ? "R3" : "R13");

      // R6: vendor byte follows bit 7 of 0x4E
      dwr(8'h4E, 8'h81); drd_chk(8'h4F, "R6");
      chk("R6", m_rd(8'h4F), 8'h5C, 8'h4F);
      dwr(8'h4E, 8'h01); drd_chk(8'h4F, "R6");

      // R5 R7 R10: alternate banks
      dwr(8'h4E, 8'h02);
      drd_chk(8'h50, "R7"); drd_chk(8'h51, "R7");
      drd_chk(8'h53, "R10"); drd_chk(8'h55, "R10");
      dwr(8'h50, 8'hEE); drd_chk(8'h50, "R7");
      dwr(8'h52, 8'h77); drd_chk(8'h52, "R7");
      drd_chk(8'h57, "R7");
      dwr(8'h4E, 8'h00); drd_chk(8'h52, "R5");
      dwr(8'h4E, 8'h06); drd_chk(8'h52, "R5");
      dwr(8'h4E, 8'h04);
      drd_chk(8'h52, "R7"); drd_chk(8'h50, "R7"); drd_chk(8'h51, "R7");
      // R2: no advance in bank 2
      set_idx(8'h56);
      acc(1'b1, 1'b0, 1'b1, 8'h00, q);
      acc(1'b0, 1'b0, 1'b1, 8'h00, q);
      chk("R2", q, 8'h56, 8'h56);
      dwr(8'h56, 8'h3C); drd_chk(8'h56, "R7");
      dwr(8'h4E, 8'h07);
      drd_chk(8'h52, "R5"); drd_chk(8'h56, "R7");

      // R11: new sensor bytes appear
      @(negedge clk);
      meas_in[7:0] = 8'h3E; meas_in[(NM-1)*8 +: 8] = 8'hC7;
      drd_chk(8'h20, "R11"); drd_chk(8'h20 + NM - 1, "R11");

      // R8: software initialise from bank 2, serial address kept
      dwr(8'h48, 8'h33);
      dwr(8'h4E, 8'h04);
      dwr(8'h40, 8'h80);
      for (int i = 0; i < 128; i++) drd_chk(i, "R8");
      dwr(8'h4E, 8'h02);
      drd_chk(8'h52, "R8"); drd_chk(8'h53, "R10");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule